// File: doc/BRIEF.md
# Region Permission Directory for a CPU and GPU Cluster Pair

This block keeps coherence permissions for two caching clusters, a CPU cluster and a GPU cluster, at the granularity of whole 1 KB regions rather than single cache lines. Each cluster's region buffer asks for Shared or Exclusive rights to a region. The directory finds the region's entry or allocates one. If the other cluster holds rights that conflict, it sends that cluster a downgrade or invalidate probe. It waits for the acknowledgement and then returns a grant.

Every accepted request occupies a slot in a small miss-status table from the moment it is accepted until its grant is taken. Entries are reused round-robin when the directory is full. Before an entry is given to a new region, every cluster still recorded as present in it is told to invalidate. Requests, probes, acknowledgements and grants are plain valid/ready channels. One entry records a region tag, a state (Invalid, Shared or Exclusive) and a presence bit for each cluster.

Top module: `region_coh_dir`

## Requirements
- R1: After reset, `req_ready` is 1 and `prb_valid` and `gnt_valid` are 0.
- R2: Cluster identifiers are 0 for CPU and 1 for GPU. A request for a region with no entry, when an unused entry exists, is granted without any probe. The grant carries the requester on `gnt_dst`, the region tag on `gnt_tag`, and `gnt_excl` (1 = Exclusive, 0 = Shared).
- R3: A Shared request is granted without a probe when the other cluster is absent or holds the region Shared. An Exclusive request is granted without a probe when the other cluster's presence bit is clear.
- R4: A Shared request to a region the other cluster holds Exclusive first sends that cluster a probe with `prb_inval` = 0 (downgrade) and the region tag.
- R5: An Exclusive request to a region in which the other cluster is present first sends that cluster a probe with `prb_inval` = 1 (invalidate). After the acknowledgement, that cluster is no longer present.
- R6: No grant is issued for a request while an acknowledgement for one of its probes is still outstanding.
- R7: When no unused entry exists, a victim is chosen round-robin among entries that no active request touches. Every cluster present in the victim receives an invalidate probe carrying the victim's tag, CPU first, then GPU, before the entry is reused. A later request for the evicted region misses and is treated as fresh.
- R8: A request whose region matches an active miss-status slot, including a slot that is still evicting that region, is held with `req_ready` = 0 until that slot completes.
- R9: When every miss-status slot is occupied, `req_ready` is 0. The number of occupied slots never exceeds the table depth.
- R10: While `prb_valid` or `gnt_valid` is 1 and the matching ready is 0, the valid signal stays high and its payload does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Permission request present |
| req_ready | output | 1 | Request accepted this cycle when both high |
| req_src | input | 1 | Requesting cluster (0 CPU, 1 GPU) |
| req_excl | input | 1 | 1 = Exclusive, 0 = Shared |
| req_tag | input | TAG_W | Region tag |
| prb_valid | output | 1 | Probe present |
| prb_ready | input | 1 | Probe taken by cluster |
| prb_dst | output | 1 | Probed cluster |
| prb_inval | output | 1 | 1 = invalidate, 0 = downgrade to Shared |
| prb_tag | output | TAG_W | Probed region tag |
| ack_valid | input | 1 | Probe acknowledgement present |
| ack_ready | output | 1 | Always 1 |
| ack_src | input | 1 | Acknowledging cluster |
| ack_tag | input | TAG_W | Acknowledged region tag |
| gnt_valid | output | 1 | Grant present |
| gnt_ready | input | 1 | Grant taken by cluster |
| gnt_dst | output | 1 | Cluster receiving the grant |
| gnt_excl | output | 1 | Granted state (1 Exclusive, 0 Shared) |
| gnt_tag | output | TAG_W | Granted region tag |

## Verification
The hardest state to reach is a full miss-status table in which some slots hold locked entries, others wait for probe answers, and the rest stall at lookup because every directory entry is locked. The bench builds it with a four-entry directory. It holds grant and probe ready low while it pushes eight distinct regions, so the first four evict and sit on unanswered probes and the last four stall. It then checks that a ninth request is refused. Finally it releases the channels and requires all eight grants, plus the ninth, to come out.

// File: rtl/rcd_pkg.sv
// Shared types for the region permission directory.
// Assumes exactly two clusters: index 0 is CPU, index 1 is GPU.
package rcd_pkg;
    localparam int NCL = 2;

    typedef enum logic [1:0] {
        RS_INV = 2'd0,
        RS_SHR = 2'd1,
        RS_EXC = 2'd2
    } rstate_e;

    typedef enum logic [1:0] {
        MS_IDLE  = 2'd0,
        MS_NEW   = 2'd1,
        MS_PROBE = 2'd2,
        MS_GRANT = 2'd3
    } mstate_e;
endpackage

// File: rtl/rcd_first_set.sv
// Lowest-index set-bit finder.
// Assumes N >= 1. idx is 0 when found is 0.
module rcd_first_set #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/rcd_dir_store.sv
// Region entry storage with combinational lookup, free-slot search and
// round-robin victim search. An entry is locked, and so never a victim,
// while an active miss-status slot carries its tag.
module rcd_dir_store
    import rcd_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 18,
    parameter int MSHRS   = 8,
    localparam int DW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [TAG_W-1:0]            lk_tag,
    input  logic [MSHRS-1:0]            m_busy,
    input  logic [MSHRS-1:0][TAG_W-1:0] m_tags,
    input  logic                        wr_en,
    input  logic                        wr_evict,
    input  logic [DW-1:0]               wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  rstate_e                     wr_state,
    input  logic [NCL-1:0]              wr_pres,
    output logic                        hit,
    output logic [DW-1:0]               hit_idx,
    output rstate_e                     hit_state,
    output logic [NCL-1:0]              hit_pres,
    output logic                        free_found,
    output logic [DW-1:0]               free_idx,
    output logic                        vic_found,
    output logic [DW-1:0]               vic_idx,
    output logic [TAG_W-1:0]            vic_tag,
    output logic [NCL-1:0]              vic_pres
);
    logic [TAG_W-1:0] d_tag   [ENTRIES];
    rstate_e          d_state [ENTRIES];
    logic [NCL-1:0]   d_pres  [ENTRIES];
    logic [DW-1:0]    rr;

    logic [ENTRIES-1:0] hit_vec, free_vec, cand_vec, cand_hi;
    logic               hi_found, all_found;
    logic [DW-1:0]      hi_idx, all_idx;

    // classify every entry against the lookup tag and the active slots
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            logic locked;
            locked = 1'b0;
            for (int m = 0; m < MSHRS; m++) begin
                if (m_busy[m] && m_tags[m] == d_tag[e]) locked = 1'b1;
            end
            hit_vec[e]  = (d_state[e] != RS_INV) && (d_tag[e] == lk_tag);
            free_vec[e] = (d_state[e] == RS_INV);
            cand_vec[e] = (d_state[e] != RS_INV) && !locked;
            cand_hi[e]  = cand_vec[e] && (DW'(e) >= rr);
        end
    end

    rcd_first_set #(.N(ENTRIES)) u_hit  (.vec(hit_vec),  .found(hit),        .idx(hit_idx));
    rcd_first_set #(.N(ENTRIES)) u_free (.vec(free_vec), .found(free_found), .idx(free_idx));
    rcd_first_set #(.N(ENTRIES)) u_vhi  (.vec(cand_hi),  .found(hi_found),   .idx(hi_idx));
    rcd_first_set #(.N(ENTRIES)) u_vall (.vec(cand_vec), .found(all_found),  .idx(all_idx));

    // victim: first unlocked entry at or after the pointer, else wrap
    always_comb begin
        vic_found = all_found;
        vic_idx   = hi_found ? hi_idx : all_idx;
        vic_tag   = d_tag[vic_idx];
        vic_pres  = d_pres[vic_idx];
        hit_state = d_state[hit_idx];
        hit_pres  = d_pres[hit_idx];
    end

    // entry writes and round-robin pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                d_tag[e]   <= '0;
                d_state[e] <= RS_INV;
                d_pres[e]  <= '0;
            end
        end else if (wr_en) begin
            d_tag[wr_idx]   <= wr_tag;
            d_state[wr_idx] <= wr_state;
            d_pres[wr_idx]  <= wr_pres;
            if (wr_evict) begin
                rr <= (32'(wr_idx) == ENTRIES - 1) ? '0 : wr_idx + DW'(1);
            end
        end
    end
endmodule

// File: rtl/region_coh_dir.sv
// Region permission directory for one CPU and one GPU cluster.
// Accepted requests enter a miss-status slot, one slot per cycle is looked
// up, the directory entry is written with its final state at lookup, and
// probes and grants leave through single-issue senders that hold their
// payload until taken. Acknowledgements are always accepted; one that
// matches no outstanding probe is dropped.
module region_coh_dir
    import rcd_pkg::*;
#(
    parameter int TAG_W       = 18,
    parameter int DIR_ENTRIES = 16,
    parameter int MSHR_DEPTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_src,
    input  logic             req_excl,
    input  logic [TAG_W-1:0] req_tag,
    output logic             prb_valid,
    input  logic             prb_ready,
    output logic             prb_dst,
    output logic             prb_inval,
    output logic [TAG_W-1:0] prb_tag,
    input  logic             ack_valid,
    output logic             ack_ready,
    input  logic             ack_src,
    input  logic [TAG_W-1:0] ack_tag,
    output logic             gnt_valid,
    input  logic             gnt_ready,
    output logic             gnt_dst,
    output logic             gnt_excl,
    output logic [TAG_W-1:0] gnt_tag
);
    localparam int MW = (MSHR_DEPTH > 1) ? $clog2(MSHR_DEPTH) : 1;
    localparam int DW = (DIR_ENTRIES > 1) ? $clog2(DIR_ENTRIES) : 1;

    mstate_e          m_st    [MSHR_DEPTH];
    logic             m_src   [MSHR_DEPTH];
    logic             m_excl  [MSHR_DEPTH];
    logic [TAG_W-1:0] m_tag   [MSHR_DEPTH];
    logic [TAG_W-1:0] m_ptag  [MSHR_DEPTH];
    logic             m_pinv  [MSHR_DEPTH];
    logic [NCL-1:0]   m_send  [MSHR_DEPTH];
    logic [NCL-1:0]   m_wait  [MSHR_DEPTH];
    logic [NCL-1:0]   ns_a    [MSHR_DEPTH];
    logic [NCL-1:0]   nw_a    [MSHR_DEPTH];

    logic [MSHR_DEPTH-1:0]            busy_v, new_v, idle_v, prb_v, gnt_v;
    logic [MSHR_DEPTH-1:0][TAG_W-1:0] tag_pk;
    logic                             tag_busy;

    logic          lk_found, id_found, pp_found, gp_found;
    logic [MW-1:0] lk_i, id_idx, pp_idx, gp_idx;
    logic          p_hold, g_hold;
    logic [MW-1:0] p_idx, g_idx, p_cur, g_cur;
    logic          prb_fire, gnt_fire, acc;

    logic             hit, free_found, vic_found;
    logic [DW-1:0]    hit_idx, free_idx, vic_idx;
    rstate_e          hit_state;
    logic [NCL-1:0]   hit_pres, vic_pres;
    logic [TAG_W-1:0] vic_tag;

    logic             lk_go, lk_evict, lk_pinv;
    logic [DW-1:0]    lk_widx;
    rstate_e          lk_wstate;
    logic [NCL-1:0]   lk_wpres, lk_pmask, own_bit, oth_bit;
    logic [TAG_W-1:0] lk_ptag;

    function automatic logic [NCL-1:0] low_bit(input logic [NCL-1:0] v);
        return v[0] ? 2'b01 : {v[1], 1'b0};
    endfunction

    // per-slot status vectors and the same-region match for the input
    always_comb begin
        tag_busy = 1'b0;
        for (int i = 0; i < MSHR_DEPTH; i++) begin
            busy_v[i] = (m_st[i] != MS_IDLE);
            new_v[i]  = (m_st[i] == MS_NEW);
            idle_v[i] = (m_st[i] == MS_IDLE);
            prb_v[i]  = (m_st[i] == MS_PROBE) && (m_send[i] != '0);
            gnt_v[i]  = (m_st[i] == MS_GRANT);
            tag_pk[i] = m_tag[i];
            if (busy_v[i] && (m_tag[i] == req_tag ||
                (m_st[i] == MS_PROBE && m_ptag[i] == req_tag))) tag_busy = 1'b1;
        end
    end

    rcd_first_set #(.N(MSHR_DEPTH)) u_pick_new  (.vec(new_v),  .found(lk_found), .idx(lk_i));
    rcd_first_set #(.N(MSHR_DEPTH)) u_pick_idle (.vec(idle_v), .found(id_found), .idx(id_idx));
    rcd_first_set #(.N(MSHR_DEPTH)) u_pick_prb  (.vec(prb_v),  .found(pp_found), .idx(pp_idx));
    rcd_first_set #(.N(MSHR_DEPTH)) u_pick_gnt  (.vec(gnt_v),  .found(gp_found), .idx(gp_idx));

    rcd_dir_store #(
        .ENTRIES(DIR_ENTRIES), .TAG_W(TAG_W), .MSHRS(MSHR_DEPTH)
    ) u_dir (
        .clk(clk), .rst_n(rst_n), .lk_tag(m_tag[lk_i]),
        .m_busy(busy_v), .m_tags(tag_pk),
        .wr_en(lk_go), .wr_evict(lk_evict), .wr_idx(lk_widx),
        .wr_tag(m_tag[lk_i]), .wr_state(lk_wstate), .wr_pres(lk_wpres),
        .hit(hit), .hit_idx(hit_idx), .hit_state(hit_state), .hit_pres(hit_pres),
        .free_found(free_found), .free_idx(free_idx),
        .vic_found(vic_found), .vic_idx(vic_idx), .vic_tag(vic_tag), .vic_pres(vic_pres)
    );

    // lookup decision for the selected new slot: final entry and probe set
    always_comb begin
        own_bit   = m_src[lk_i] ? 2'b10 : 2'b01;
        oth_bit   = ~own_bit;
        lk_go     = 1'b0;
        lk_evict  = 1'b0;
        lk_widx   = hit_idx;
        lk_wstate = m_excl[lk_i] ? RS_EXC : RS_SHR;
        lk_wpres  = own_bit;
        lk_pmask  = '0;
        lk_ptag   = m_tag[lk_i];
        lk_pinv   = 1'b1;
        if (lk_found) begin
            if (hit) begin
                lk_go = 1'b1;
                if (m_excl[lk_i]) begin
                    lk_pmask = hit_pres & oth_bit;
                end else begin
                    lk_wpres = hit_pres | own_bit;
                    lk_pinv  = 1'b0;
                    lk_pmask = (hit_state == RS_EXC) ? (hit_pres & oth_bit) : '0;
                end
            end else if (free_found) begin
                lk_go   = 1'b1;
                lk_widx = free_idx;
            end else if (vic_found) begin
                lk_go    = 1'b1;
                lk_evict = 1'b1;
                lk_widx  = vic_idx;
                lk_pmask = vic_pres;
                lk_ptag  = vic_tag;
            end
        end
    end

    // sender selection, held while the receiver stalls
    always_comb begin
        p_cur     = p_hold ? p_idx : pp_idx;
        g_cur     = g_hold ? g_idx : gp_idx;
        prb_valid = p_hold | pp_found;
        gnt_valid = g_hold | gp_found;
        prb_dst   = ~m_send[p_cur][0];
        prb_inval = m_pinv[p_cur];
        prb_tag   = m_ptag[p_cur];
        gnt_dst   = m_src[g_cur];
        gnt_excl  = m_excl[g_cur];
        gnt_tag   = m_tag[g_cur];
        prb_fire  = prb_valid & prb_ready;
        gnt_fire  = gnt_valid & gnt_ready;
        ack_ready = 1'b1;
        req_ready = id_found & ~tag_busy & ~lk_evict;
        acc       = req_valid & req_ready;
    end

    // next probe-to-send and awaiting-ack masks of every slot
    always_comb begin
        for (int i = 0; i < MSHR_DEPTH; i++) begin
            ns_a[i] = m_send[i];
            nw_a[i] = m_wait[i];
            if (prb_fire && p_cur == MW'(i)) begin
                ns_a[i] = m_send[i] & ~low_bit(m_send[i]);
                nw_a[i] = m_wait[i] | low_bit(m_send[i]);
            end
            if (ack_valid && m_st[i] == MS_PROBE && m_ptag[i] == ack_tag && nw_a[i][ack_src])
                nw_a[i][ack_src] = 1'b0;
        end
    end

    // slot life cycle: accept, lookup, probe, grant, free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_hold <= 1'b0;
            g_hold <= 1'b0;
            p_idx  <= '0;
            g_idx  <= '0;
            for (int i = 0; i < MSHR_DEPTH; i++) begin
                m_st[i]   <= MS_IDLE;
                m_src[i]  <= 1'b0;
                m_excl[i] <= 1'b0;
                m_tag[i]  <= '0;
                m_ptag[i] <= '0;
                m_pinv[i] <= 1'b0;
                m_send[i] <= '0;
                m_wait[i] <= '0;
            end
        end else begin
            p_hold <= prb_valid & ~prb_ready;
            g_hold <= gnt_valid & ~gnt_ready;
            p_idx  <= p_cur;
            g_idx  <= g_cur;
            for (int i = 0; i < MSHR_DEPTH; i++) begin
                if (acc && id_idx == MW'(i)) begin
                    m_st[i]   <= MS_NEW;
                    m_src[i]  <= req_src;
                    m_excl[i] <= req_excl;
                    m_tag[i]  <= req_tag;
                end
                if (lk_go && lk_i == MW'(i)) begin
                    m_st[i]   <= (lk_pmask != '0) ? MS_PROBE : MS_GRANT;
                    m_ptag[i] <= lk_ptag;
                    m_pinv[i] <= lk_pinv;
                    m_send[i] <= lk_pmask;
                    m_wait[i] <= '0;
                end
                if (m_st[i] == MS_PROBE) begin
                    m_send[i] <= ns_a[i];
                    m_wait[i] <= nw_a[i];
                    if (ns_a[i] == '0 && nw_a[i] == '0) m_st[i] <= MS_GRANT;
                end
                if (gnt_fire && g_cur == MW'(i)) m_st[i] <= MS_IDLE;
            end
        end
    end
endmodule

// File: rtl/rcd_checker.sv
// Port-level protocol checks for region_coh_dir, attached by bind.
// Keeps its own occupancy count from request and grant handshakes.
module rcd_checker #(
    parameter int TAG_W      = 18,
    parameter int MSHR_DEPTH = 8,
    localparam int CW = $clog2(MSHR_DEPTH + 1) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             prb_valid,
    input logic             prb_ready,
    input logic             prb_dst,
    input logic             prb_inval,
    input logic [TAG_W-1:0] prb_tag,
    input logic             gnt_valid,
    input logic             gnt_ready,
    input logic             gnt_dst,
    input logic             gnt_excl,
    input logic [TAG_W-1:0] gnt_tag
);
    logic [CW-1:0] occ;

    // outstanding requests: accepted minus granted
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else occ <= occ + CW'(req_valid && req_ready) - CW'(gnt_valid && gnt_ready);
    end

    AST_RST_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!prb_valid && !gnt_valid)); // R1

    AST_PRB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid && !prb_ready) |=> (prb_valid && $stable(prb_dst) &&
        $stable(prb_inval) && $stable(prb_tag))); // R10

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !gnt_ready) |=> (gnt_valid && $stable(gnt_dst) &&
        $stable(gnt_excl) && $stable(gnt_tag))); // R10

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(MSHR_DEPTH)) |-> !req_ready); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(MSHR_DEPTH)); // R9
endmodule

bind region_coh_dir rcd_checker #(.TAG_W(TAG_W), .MSHR_DEPTH(MSHR_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_dst(prb_dst),
    .prb_inval(prb_inval), .prb_tag(prb_tag), .gnt_valid(gnt_valid),
    .gnt_ready(gnt_ready), .gnt_dst(gnt_dst), .gnt_excl(gnt_excl), .gnt_tag(gnt_tag)
);

// File: tb/region_coh_dir_tb.sv
// Bench: vector table of serial requests with expected probes and grants,
// then directed tests for reset, same-region hold and a full table.
module region_coh_dir_tb;
    localparam int CLK_P = 10;
    localparam int TW    = 18;
    localparam int NV    = 15;

    typedef struct packed {
        logic       src;
        logic       excl;
        logic [7:0] tag;
        logic [1:0] pmask;
        logic       pinv;
        logic [7:0] ptag;
        logic       gexcl;
    } vec_t;

    // directory has 4 entries, so rows 10, 11 and 13 evict
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h10, 2'b00, 1'b0, 8'h00, 1'b0}, // R2 fresh
        '{1'b1, 1'b0, 8'h10, 2'b00, 1'b0, 8'h00, 1'b0}, // R3 shared/shared
        '{1'b1, 1'b1, 8'h10, 2'b01, 1'b1, 8'h10, 1'b1}, // R5 invalidate CPU
        '{1'b0, 1'b0, 8'h10, 2'b10, 1'b0, 8'h10, 1'b0}, // R4 downgrade GPU
        '{1'b0, 1'b1, 8'h10, 2'b10, 1'b1, 8'h10, 1'b1}, // R5 invalidate GPU
        '{1'b0, 1'b1, 8'h10, 2'b00, 1'b0, 8'h00, 1'b1}, // R3 sole owner
        '{1'b1, 1'b0, 8'h20, 2'b00, 1'b0, 8'h00, 1'b0}, // R2
        '{1'b0, 1'b0, 8'h30, 2'b00, 1'b0, 8'h00, 1'b0}, // R2
        '{1'b1, 1'b1, 8'h40, 2'b00, 1'b0, 8'h00, 1'b1}, // R2
        '{1'b0, 1'b0, 8'h20, 2'b00, 1'b0, 8'h00, 1'b0}, // R3
        '{1'b0, 1'b0, 8'h50, 2'b01, 1'b1, 8'h10, 1'b0}, // R7 victim entry 0
        '{1'b1, 1'b1, 8'h60, 2'b11, 1'b1, 8'h20, 1'b1}, // R7 two sharers
        '{1'b0, 1'b0, 8'h40, 2'b10, 1'b0, 8'h40, 1'b0}, // R4
        '{1'b1, 1'b0, 8'h10, 2'b01, 1'b1, 8'h30, 1'b0}, // R7 refetch evicted
        '{1'b0, 1'b1, 8'h60, 2'b10, 1'b1, 8'h60, 1'b1}  // R5
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_src = 1'b0, req_excl = 1'b0;
    logic [TW-1:0] req_tag = '0, ack_tag = '0;
    logic prb_ready = 1'b0, ack_valid = 1'b0, ack_src = 1'b0, gnt_ready = 1'b0;
    logic req_ready, prb_valid, prb_dst, prb_inval, ack_ready;
    logic gnt_valid, gnt_dst, gnt_excl;
    logic [TW-1:0] prb_tag, gnt_tag;

    int total = 0, bad = 0;
    bit finished = 0;

    region_coh_dir #(.TAG_W(TW), .DIR_ENTRIES(4), .MSHR_DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_excl(req_excl), .req_tag(req_tag),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_dst(prb_dst),
        .prb_inval(prb_inval), .prb_tag(prb_tag), .ack_valid(ack_valid),
        .ack_ready(ack_ready), .ack_src(ack_src), .ack_tag(ack_tag),
        .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_dst(gnt_dst),
        .gnt_excl(gnt_excl), .gnt_tag(gnt_tag)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic send_req(input logic s, input logic x, input logic [TW-1:0] t,
                            output bit ok);
        ok = 0;
        @(negedge clk);
        req_valid = 1; req_src = s; req_excl = x; req_tag = t;
        for (int k = 0; k < 200 && !ok; k++) begin
            #(CLK_P / 4);
            if (req_ready) begin
                ok = 1;
                @(posedge clk);
            end
            @(negedge clk);
        end
        req_valid = 0;
    endtask

    task automatic expect_probe(input logic d, input logic inv, input logic [TW-1:0] t,
                                input string rq);
        bit seen = 0;
        for (int k = 0; k < 100 && !seen; k++) begin
            @(negedge clk);
            seen = prb_valid;
        end
        chk(seen, rq, "probe present", seen, 1);
        if (!seen) return;
        chk(prb_dst == d, rq, "probe cluster", prb_dst, d);
        chk(prb_inval == inv, rq, "probe kind", prb_inval, inv);
        chk(prb_tag == t, rq, "probe tag", prb_tag, t);
        @(negedge clk);
        @(negedge clk);
        chk(prb_valid && prb_dst == d && prb_tag == t, "R10", "probe held", prb_tag, t);
        prb_ready = 1;
        @(posedge clk);
        @(negedge clk);
        prb_ready = 0;
        @(negedge clk);
        chk(!gnt_valid, "R6", "grant before ack", gnt_valid, 0);
        ack_valid = 1; ack_src = d; ack_tag = t;
        @(negedge clk);
        ack_valid = 0;
    endtask

    task automatic expect_grant(input logic d, input logic x, input logic [TW-1:0] t,
                                input string rq);
        bit seen = 0, stray = 0;
        for (int k = 0; k < 100 && !seen; k++) begin
            @(negedge clk);
            if (prb_valid) stray = 1;
            seen = gnt_valid;
        end
        chk(!stray, rq, "unexpected probe", stray, 0);
        chk(seen, rq, "grant present", seen, 1);
        if (!seen) return;
        chk(gnt_dst == d, "R2", "grant cluster", gnt_dst, d);
        chk(gnt_excl == x, rq, "grant state", gnt_excl, x);
        chk(gnt_tag == t, "R2", "grant tag", gnt_tag, t);
        gnt_ready = 1;
        @(posedge clk);
        @(negedge clk);
        gnt_ready = 0;
    endtask

    // answer every probe and take grants until 'want' grants are seen
    task automatic drain(input int want, output int got);
        bit pend = 0;
        logic pd = 0;
        logic [TW-1:0] pt = '0;
        got = 0;
        for (int c = 0; c < 3000 && got < want; c++) begin
            @(negedge clk);
            ack_valid = 0;
            if (pend) begin
                ack_valid = 1; ack_src = pd; ack_tag = pt; pend = 0;
            end
            prb_ready = 0;
            gnt_ready = 0;
            if (prb_valid) begin
                prb_ready = 1; pend = 1; pd = prb_dst; pt = prb_tag;
            end
            if (gnt_valid) begin
                gnt_ready = 1; got++;
            end
        end
        @(negedge clk);
        prb_ready = 0; gnt_ready = 0; ack_valid = 0;
        if (pend) begin
            ack_valid = 1; ack_src = pd; ack_tag = pt;
        end
        @(negedge clk);
        ack_valid = 0;
    endtask

    initial begin
        bit ok;
        int got;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        chk(prb_valid == 0, "R1", "probe after reset", prb_valid, 0);
        chk(gnt_valid == 0, "R1", "grant after reset", gnt_valid, 0);

        for (int v = 0; v < NV; v++) begin
            vec_t e;
            string rq;
            e = VECS[v];
            rq = (e.pmask == 2'b00) ? ((v == 0 || (v >= 6 && v <= 8)) ? "R2" : "R3") :
                 (e.ptag != e.tag) ? "R7" : (e.pinv ? "R5" : "R4");
            send_req(e.src, e.excl, {10'b0, e.tag}, ok);
            chk(ok, rq, "request accepted", ok, 1);
            if (e.pmask[0]) expect_probe(1'b0, e.pinv, {10'b0, e.ptag}, rq);
            if (e.pmask[1]) expect_probe(1'b1, e.pinv, {10'b0, e.ptag}, rq);
            expect_grant(e.src, e.gexcl, {10'b0, e.tag}, rq);
        end

        // R8: second request to a region with an active slot is held
        send_req(1'b0, 1'b0, 18'h50, ok);
        repeat (3) @(negedge clk);
        chk(gnt_valid, "R8", "first grant pending", gnt_valid, 1);
        req_valid = 1; req_src = 1; req_excl = 0; req_tag = 18'h50;
        begin
            bit held = 1;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (req_ready) held = 0;
            end
            chk(held, "R8", "same-region held", !held, 0);
        end
        req_valid = 0;
        expect_grant(1'b0, 1'b0, 18'h50, "R8");
        send_req(1'b1, 1'b0, 18'h50, ok);
        chk(ok, "R8", "accepted after release", ok, 1);
        expect_grant(1'b1, 1'b0, 18'h50, "R8");

        // R9: fill all slots with grants and probes stalled
        for (int k = 0; k < 8; k++) begin
            send_req(1'b0, 1'b0, 18'h100 + TW'(k), ok);
            chk(ok, "R9", "fill accepted", ok, 1);
        end
        @(negedge clk);
        req_valid = 1; req_src = 1; req_excl = 0; req_tag = 18'h200;
        #(CLK_P / 4);
        chk(!req_ready, "R9", "full table ready", req_ready, 0);
        @(negedge clk);
        chk(!req_ready, "R9", "full table ready later", req_ready, 0);
        req_valid = 0;
        drain(8, got);
        chk(got == 8, "R9", "grants after drain", got, 8);
        send_req(1'b1, 1'b0, 18'h200, ok);
        chk(ok, "R9", "accepted after drain", ok, 1);
        drain(1, got);
        chk(got == 1, "R7", "grant after eviction drain", got, 1);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule